// File: doc/BRIEF.md
# Serial Framed Two's Complement Negator

This block negates numbers that arrive one bit per clock, least significant bit first, on a single data line. A frame-start strobe is high in the cycle that carries the lowest bit of each new number. The number runs until the next cycle with the strobe high, so every frame can have a different length. The block produces the matching bit of the negated value in the same cycle as the input bit. It holds no frame buffer and has no length limit.

The block works by adding one to the bitwise inverse of the input. In practice this means a single stored bit records whether a 1 has already been seen in the current frame. While no 1 has been seen, the carry of the "+1" is still pending, so each input bit passes through unchanged, and this includes that first 1 itself. From the bit after the first 1 until the next frame start, every bit is inverted. The strobe wipes the stored bit for the cycle it arrives in, so leftover state from the previous frame never touches the new frame's first bit.

Top module: `serial_negator`

## Requirements
- R1: In a cycle with `sync_i` high, `neg_o` equals `data_i`, whatever the previous frame left behind.
- R2: Within a frame, every 0 bit received before the first 1 is output as 0.
- R3: The first 1 bit of a frame is output as 1.
- R4: Every bit after the first 1 of a frame is output inverted, up to but not including the next cycle with `sync_i` high.
- R5: `neg_o` is a combinational (Mealy) function of the current `data_i`, `sync_i` and the stored state, so it is valid in the same cycle as its input bit.
- R6: Synchronous active-high `rst` clears the stored state. After reset, bits that arrive before any `sync_i` are treated as the start of a frame.
- R7: A frame made only of 0 bits gives only 0 bits at the output and leaves the following frame unaffected.
- R8: Over a complete frame of n bits, the output bits, read least significant first, form (2^n − value) mod 2^n. For example, with sync 1,0,0,0,0,0,1,0,0,0,0,0,0,0 and data 1,0,0,1,1,1,0,0,0,1,1,0,1,0, the output is 1,1,1,0,0,0,0,0,0,1,0,1,0,1.
- R9: Back-to-back frames of one bit each (`sync_i` high every cycle) output the data unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock, one data bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| sync_i | input | 1 | High in the cycle carrying the lowest bit of a new number |
| data_i | input | 1 | Serial number bit, least significant first |
| neg_o | output | 1 | Serial negated bit, same cycle as its input |

## Verification
The hardest case to reach is a frame start that arrives while the invert state is set. It takes an earlier frame that contained a 1 and then ended with the strobe, and it matters most when the new first bit is 0. The stimulus sends frames back to back, choosing values whose upper bits are 1 so that the state is still set at each boundary, and then follows them with zero frames and one-bit frames. Same-cycle behaviour is shown by toggling `data_i` inside one clock period and watching `neg_o` follow it, in both pass and invert mode.

// File: rtl/serneg_pkg.sv
package serneg_pkg;

    // Stored machine state: set once the pending "+1" carry has been absorbed
    typedef struct packed {
        logic invert;
    } serneg_state_t;

    localparam serneg_state_t SERNEG_RESET = '{invert: 1'b0};

endpackage

// File: rtl/serneg_out.sv
module serneg_out (
    input  logic sync_i,
    input  logic data_i,
    input  logic invert_q,
    output logic carry_pending_o,
    output logic neg_o
);

    // A frame start forces the carry back to pending for this very bit
    always_comb begin
        carry_pending_o = sync_i | ~invert_q;
        neg_o           = data_i ^ ~carry_pending_o;
    end

endmodule

// File: rtl/serneg_state.sv
module serneg_state
    import serneg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic carry_pending_i,
    input  logic data_i,
    output logic invert_q
);

    serneg_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        // Carry stays pending only while the input bit is 0
        state_d.invert = ~carry_pending_i | data_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SERNEG_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    assign invert_q = state_q.invert;

endmodule

// File: rtl/serial_negator.sv
module serial_negator (
    input  logic clk,
    input  logic rst,
    input  logic sync_i,
    input  logic data_i,
    output logic neg_o
);

    logic invert_q;
    logic carry_pending;

    serneg_out i_out (
        .sync_i          (sync_i),
        .data_i          (data_i),
        .invert_q        (invert_q),
        .carry_pending_o (carry_pending),
        .neg_o           (neg_o)
    );

    serneg_state i_state (
        .clk             (clk),
        .rst             (rst),
        .carry_pending_i (carry_pending),
        .data_i          (data_i),
        .invert_q        (invert_q)
    );

endmodule

// File: rtl/serial_negator_chk.sv
module serial_negator_chk (
    input logic clk,
    input logic rst,
    input logic sync_i,
    input logic data_i,
    input logic neg_o
);

    // R1: a frame-start bit always passes through
    p_sync_passes_r1: assert property (@(posedge clk) disable iff (rst)
        sync_i |-> (neg_o == data_i));

    // R2: a 0 seen in pass mode keeps the machine in pass mode
    p_zero_keeps_pass_r2: assert property (@(posedge clk) disable iff (rst)
        (!data_i && neg_o == data_i) |=> (neg_o == data_i));

    // R4: once a 1 has been received, the next bit is inverted unless a frame starts
    p_after_one_inverts_r4: assert property (@(posedge clk) disable iff (rst)
        data_i |=> (sync_i || neg_o != data_i));

    // R4: invert mode persists until a frame start
    p_invert_persists_r4: assert property (@(posedge clk) disable iff (rst)
        (!data_i && neg_o != data_i) |=> (sync_i || neg_o != data_i));

    // R6: the first cycle after reset behaves like a frame start
    p_reset_start_r6: assert property (@(posedge clk)
        rst |=> (neg_o == data_i));

endmodule

bind serial_negator serial_negator_chk i_chk (
    .clk    (clk),
    .rst    (rst),
    .sync_i (sync_i),
    .data_i (data_i),
    .neg_o  (neg_o)
);

// File: tb/test_serial_negator.sv
module test_serial_negator;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sync_i = 1'b0;
    logic data_i = 1'b0;
    logic neg_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    serial_negator i_serial_negator (
        .clk    (clk),
        .rst    (rst),
        .sync_i (sync_i),
        .data_i (data_i),
        .neg_o  (neg_o)
    );

    task automatic check(input logic got, input logic exp, input string req);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0b expected %0b at %0t", req, got, exp, $time);
        end
    endtask

    // Drive one bit after the falling edge, sample before the rising edge
    task automatic drive(input logic s, input logic d);
        @(negedge clk);
        sync_i = s;
        data_i = d;
        #1;
    endtask

    // Send one frame and compare against the arithmetic negation (R8)
    task automatic send_frame(input int n, input logic [63:0] v, input logic first_sync);
        logic [63:0] mask;
        logic [63:0] exp;
        logic seen_one;
        mask = (n >= 64) ? '1 : ((64'd1 << n) - 64'd1);
        exp  = (~v + 64'd1) & mask;
        seen_one = 1'b0;
        for (int i = 0; i < n; i++) begin
            drive((i == 0) ? first_sync : 1'b0, v[i]);
            if (i == 0 && first_sync) check(neg_o, exp[i], "R1/R8");
            else if (!seen_one && !v[i]) check(neg_o, exp[i], "R2/R8");
            else if (!seen_one) check(neg_o, exp[i], "R3/R8");
            else check(neg_o, exp[i], "R4/R8");
            if (v[i]) seen_one = 1'b1;
        end
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (2) drive(1'b0, 1'b0);
        check(neg_o, 1'b0, "R6 reset output");
        @(negedge clk);
        rst = 1'b0;
        // R6: bits before any sync act as a frame start: 0,0,1,1,0 -> 0,0,1,0,1
        drive(1'b0, 1'b0); check(neg_o, 1'b0, "R6");
        drive(1'b0, 1'b0); check(neg_o, 1'b0, "R6");
        drive(1'b0, 1'b1); check(neg_o, 1'b1, "R6");
        drive(1'b0, 1'b1); check(neg_o, 1'b0, "R6");
        drive(1'b0, 1'b0); check(neg_o, 1'b1, "R6");
    endtask

    task automatic t_example;
        logic [13:0] s = 14'b00000001000001;
        logic [13:0] d = 14'b01011000111001;
        logic [13:0] o = 14'b10101000000111;
        for (int i = 0; i < 14; i++) begin
            drive(s[i], d[i]);
            check(neg_o, o[i], "R8 example");
        end
    endtask

    task automatic t_mealy;
        // R5: pass mode, output follows data within one period
        @(negedge clk);
        sync_i = 1'b1; data_i = 1'b0; #0.5;
        check(neg_o, 1'b0, "R5 pass low");
        data_i = 1'b1; #0.5;
        check(neg_o, 1'b1, "R5 pass high");
        // next cycle in invert mode
        @(negedge clk);
        sync_i = 1'b0; data_i = 1'b0; #0.5;
        check(neg_o, 1'b1, "R5 invert low");
        data_i = 1'b1; #0.5;
        check(neg_o, 1'b0, "R5 invert high");
        // sync in same cycle cancels inversion
        sync_i = 1'b1; #0.5;
        check(neg_o, 1'b1, "R5 sync cancels");
    endtask

    task automatic t_sync_restart;
        // Leave invert set, then start frames whose first bit is 0 and 1
        send_frame(8, 64'hF1, 1'b1);
        drive(1'b1, 1'b0); check(neg_o, 1'b0, "R1 zero after invert");
        drive(1'b0, 1'b1); check(neg_o, 1'b1, "R3 after restart");
        drive(1'b1, 1'b1); check(neg_o, 1'b1, "R1 one after invert");
    endtask

    task automatic t_zero_frame;
        send_frame(6, 64'hFF, 1'b1);
        for (int i = 0; i < 10; i++) begin
            drive(i == 0, 1'b0);
            check(neg_o, 1'b0, "R7 zero frame");
        end
        send_frame(5, 64'h14, 1'b1);
    endtask

    task automatic t_single_bits;
        logic [11:0] pat = 12'b101100111010;
        for (int i = 0; i < 12; i++) begin
            drive(1'b1, pat[i]);
            check(neg_o, pat[i], "R9 one-bit frames");
        end
    endtask

    task automatic t_various;
        send_frame(1, 64'h1, 1'b1);
        send_frame(4, 64'h8, 1'b1);
        send_frame(16, 64'h8000, 1'b1);
        send_frame(16, 64'hA5C3, 1'b1);
        send_frame(32, 64'hDEAD_BEEF, 1'b1);
        send_frame(40, 64'h12_3456_7800, 1'b1);
        send_frame(64, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
    endtask

    initial begin
        t_reset();
        t_example();
        t_mealy();
        t_sync_restart();
        t_zero_frame();
        t_single_bits();
        t_various();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule